// File: doc/BRIEF.md
# OR-Merged Carry Approximate Adder

This block adds two unsigned operands approximately, trading exactness in the low-order bits for a shorter carry chain. The operand is cut into two pieces. The upper piece is summed exactly by a carry-free precise adder. The lower piece is approximated with simple per-bit gates and a field of constant ones.

A carry predicted from the lower piece is never fed into the precise adder. It is merged with an OR gate onto the precise adder's least significant sum bit, so the critical path does not grow. When that merge is too small, because the predicted carry is 1 and the bit it lands on is already 1, a correction path drives every gate-computed bit of the lower piece to 1. This shrinks the resulting error distance.

An optional output register, with a synchronous active-high clear, can be enabled. With the register off, the block is purely combinational.

Top module: `spec_or_adder`

## Requirements
- R1: With P = a[15:8] + b[15:8] as a 9-bit value, the outputs `cout` and `sum[15:9]` equal P[8] and P[7:1].
- R2: The predicted carry is a[7] AND b[7]. `sum[8]` equals that carry OR P[0].
- R3: When the correction is inactive, `sum[7]` equals a[7] XOR b[7].
- R4: When the correction is inactive, each of the next lower OR_W-1 bits of `sum` (bits 6 down to 8-OR_W) equals the OR of the two operand bits at that position.
- R5: `sum[7-OR_W:0]` is all ones for every input pattern.
- R6: The correction is active when a[7]&b[7] is 1 and P[0] is 1. While it is active, `sum[7:8-OR_W]` are all 1.
- R7: When the predicted carry is 0, or P[0] is 0, the correction changes no output bit.
- R8: With REGISTERED=1, the outputs update on the rising clock edge from the inputs present before that edge. While `rst` is high at an edge, the outputs are cleared to zero.
- R9: With REGISTERED=0, the outputs follow an input change without any clock edge.
- R10: Over uniform random inputs, the fraction of results that differ from the exact 17-bit sum is 1 - (7/8)(3/4)^(OR_W-1)(1/2)^(8-OR_W), within 0.5 percentage points. This is checked for OR_W = 3 and OR_W = 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1  | Clock for the optional output register |
| rst  | input  | 1  | Synchronous active-high clear of the output register |
| a    | input  | WIDTH | First operand |
| b    | input  | WIDTH | Second operand |
| sum  | output | WIDTH | Approximate sum |
| cout | output | 1  | Carry out of the precise upper adder |

## Verification
The hardest condition to reach is the correction path. It needs a[7] and b[7] both set and also an odd exact upper sum, so about one random pair in eight hits it. When it fires, the only difference from the uncorrected result is in the few gate-computed bits. Directed pairs force this case and its near neighbours, such as a predicted carry onto an even upper sum. A long random run then supplies enough hits, and also enough samples to compare the measured error rate with the closed-form value for both lower-piece splits.

// File: rtl/spec_or_adder.sv
module spec_or_adder #(
  parameter int WIDTH      = 16,
  parameter int EXACT_W    = 8,
  parameter int OR_W       = 3,
  parameter bit REGISTERED = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int LO      = WIDTH - EXACT_W;
  localparam int CONST_W = LO - OR_W;

  if (EXACT_W < 1 || EXACT_W >= WIDTH || OR_W < 1 || OR_W > LO - 1) begin : g_bad_params
    $fatal(1, "spec_or_adder: illegal WIDTH/EXACT_W/OR_W combination");
  end

  logic [EXACT_W:0]   hi_sum;
  logic               spec_c;
  logic               fix;
  logic [OR_W-1:0]    gate_bits;
  logic [WIDTH-1:0]   res;

  assign hi_sum = {1'b0, a[WIDTH-1:LO]} + {1'b0, b[WIDTH-1:LO]};
  assign spec_c = a[LO-1] & b[LO-1];
  assign fix    = spec_c & hi_sum[0];

  assign gate_bits[OR_W-1] = (a[LO-1] ^ b[LO-1]) | fix;
  if (OR_W > 1) begin : g_or_bits
    assign gate_bits[OR_W-2:0] = a[LO-2:CONST_W] | b[LO-2:CONST_W] | {(OR_W-1){fix}};
  end

  assign res = {hi_sum[EXACT_W-1:1], hi_sum[0] | spec_c, gate_bits, {CONST_W{1'b1}}};

  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        sum  <= '0;
        cout <= 1'b0;
      end else begin
        sum  <= res;
        cout <= hi_sum[EXACT_W];
      end
    end

    // R1
    upper_pass_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> {cout, sum[WIDTH-1:LO+1]} ==
        (({1'b0, $past(a[WIDTH-1:LO])} + {1'b0, $past(b[WIDTH-1:LO])}) >> 1));
    // R2
    merge_lsb_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> sum[LO] == (($past(a[LO-1]) & $past(b[LO-1])) | ($past(a[LO]) ^ $past(b[LO]))));
    // R5
    const_low_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> &sum[CONST_W-1:0]);
    // R6
    err_reduce_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(a[LO-1] & b[LO-1]) && $past(a[LO] ^ b[LO])) |-> &sum[LO-1:CONST_W]);
    // R3
    half_sum_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !($past(a[LO-1] & b[LO-1]) && $past(a[LO] ^ b[LO])))
        |-> sum[LO-1] == ($past(a[LO-1]) ^ $past(b[LO-1])));
  end else begin : g_comb
    assign sum  = res;
    assign cout = hi_sum[EXACT_W];

    // R1
    upper_pass_chk: assert property (@(posedge clk) disable iff (rst)
      {cout, sum[WIDTH-1:LO+1]} == (({1'b0, a[WIDTH-1:LO]} + {1'b0, b[WIDTH-1:LO]}) >> 1));
    // R2
    merge_lsb_chk: assert property (@(posedge clk) disable iff (rst)
      sum[LO] == ((a[LO-1] & b[LO-1]) | (a[LO] ^ b[LO])));
    // R5
    const_low_chk: assert property (@(posedge clk) disable iff (rst)
      &sum[CONST_W-1:0]);
    // R6
    err_reduce_chk: assert property (@(posedge clk) disable iff (rst)
      (a[LO-1] & b[LO-1] & (a[LO] ^ b[LO])) |-> &sum[LO-1:CONST_W]);
  end
endmodule

// File: tb/sim_spec_or_adder.sv
module sim_spec_or_adder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a = '0, b = '0;
  logic [15:0] s0, s1;
  logic        c0, c1;
  int checks = 0, errors = 0;
  int wrong3 = 0, wrong4 = 0, nrand = 0;
  longint dist3 = 0, dist4 = 0;

  always #2 clk = ~clk;

  spec_or_adder #(.WIDTH(16), .EXACT_W(8), .OR_W(3), .REGISTERED(1'b1)) u0 (
    .clk(clk), .rst(rst), .a(a), .b(b), .sum(s0), .cout(c0));
  spec_or_adder #(.WIDTH(16), .EXACT_W(8), .OR_W(4), .REGISTERED(1'b0)) u1 (
    .clk(clk), .rst(rst), .a(a), .b(b), .sum(s1), .cout(c1));

  function automatic logic [16:0] model(input logic [15:0] x, input logic [15:0] y, input int l);
    logic [8:0]  p;
    logic [15:0] r;
    logic        cin, fx;
    p   = {1'b0, x[15:8]} + {1'b0, y[15:8]};
    cin = x[7] & y[7];
    fx  = cin & p[0];
    r[15:9] = p[7:1];
    r[8]    = p[0] | cin;
    r[7]    = (x[7] ^ y[7]) | fx;
    for (int i = 0; i < 7; i++)
      r[i] = (i >= 8 - l) ? ((x[i] | y[i]) | fx) : 1'b1;
    return {p[8], r};
  endfunction

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] x, input logic [15:0] y, input string req);
    a = x; b = y;
    @(negedge clk);
    check(req, {c0, s0}, model(x, y, 3));
    check(req, {c1, s1}, model(x, y, 4));
  endtask

  initial begin
    #(4 * 190000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [16:0] ex;
    int d;
    real r3, r4, e3, e4;
    void'($urandom(32'd1234));
    // R8 reset clears the register
    a = 16'hFFFF; b = 16'hFFFF;
    repeat (3) @(negedge clk);
    check("R8 reset", {c0, s0}, 17'h0);
    rst = 1'b0;
    // R9 combinational path needs no edge
    a = 16'h1234; b = 16'h0101; #1;
    check("R9 comb", {c1, s1}, model(16'h1234, 16'h0101, 4));
    @(negedge clk);
    check("R8 capture", {c0, s0}, model(16'h1234, 16'h0101, 3));
    // R5 zeros: only constant field ones
    apply(16'h0000, 16'h0000, "R5 zero");
    check("R5 zero l3", {c0, s0}, 17'h0001F);
    check("R5 zero l4", {c1, s1}, 17'h0000F);
    // R6 correction: hi lsb 1 plus predicted carry
    apply(16'h0180, 16'h0080, "R6 fix");
    check("R6 fix l3", {c0, s0}, 17'h001FF);
    check("R6 fix l4", {c1, s1}, 17'h001FF);
    // R7 carry onto even upper sum: no correction
    apply(16'h0080, 16'h0080, "R7 nofix");
    check("R7 nofix l3", {c0, s0}, 17'h0011F);
    // R7 upper lsb 1 but no carry: OR bits untouched
    apply(16'h0120, 16'h0000, "R7 nocarry");
    check("R7 nocarry l3", {c0, s0}, 17'h0013F);
    // R1 carry out
    apply(16'hFF00, 16'hFF00, "R1 cout");
    check("R1 cout l3", {c0, s0}, 17'h1FE1F);
    // R3 R4 bit patterns
    apply(16'h00C0, 16'h0040, "R3 R4 mix");
    apply(16'h0060, 16'h0030, "R4 or");
    apply(16'hFFFF, 16'h0001, "R2 wrap");
    // R10 random run with bit-exact comparison
    for (int n = 0; n < 60000; n++) begin
      logic [15:0] x, y;
      x = 16'($urandom); y = 16'($urandom);
      apply(x, y, "R10 rand");
      ex = {1'b0, x} + {1'b0, y};
      nrand++;
      if ({c0, s0} != ex) wrong3++;
      if ({c1, s1} != ex) wrong4++;
      d = int'({c0, s0}) - int'(ex); dist3 += (d < 0) ? -d : d;
      d = int'({c1, s1}) - int'(ex); dist4 += (d < 0) ? -d : d;
    end
    r3 = real'(wrong3) / nrand;
    r4 = real'(wrong4) / nrand;
    e3 = 1.0 - 0.875 * (0.75 ** 2) * (0.5 ** 5);
    e4 = 1.0 - 0.875 * (0.75 ** 3) * (0.5 ** 4);
    $display("mean error distance l3=%0f l4=%0f", real'(dist3) / nrand, real'(dist4) / nrand);
    checks++;
    if (r3 < e3 - 0.005 || r3 > e3 + 0.005) begin
      errors++; $display("FAIL R10 l3 rate actual=%0f expected=%0f", r3, e3);
    end
    checks++;
    if (r4 < e4 - 0.005 || r4 > e4 + 0.005) begin
      errors++; $display("FAIL R10 l4 rate actual=%0f expected=%0f", r4, e4);
    end
    // R8 synchronous clear mid-run
    rst = 1'b1; a = 16'h5555; b = 16'h3333;
    @(negedge clk);
    check("R8 clear", {c0, s0}, 17'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule